// File: doc/BRIEF.md
# Bitsliced AES State Transposer

This block turns eight independent 128-bit AES blocks into eight 128-bit bit planes, and turns eight planes back into eight blocks. Bitsliced AES datapaths use this form. Each plane collects one bit position of every byte in all eight blocks. The block is laid out so that every round operation works at byte granularity or coarser. Only the reordering and its sequencing are here. Round functions, key expansion and S-box logic sit elsewhere.

A mode input sets the direction for the next batch, and the block reads it only while idle. In pack mode the block takes one AES block per handshake over eight beats. It then presents all eight planes at once. In unpack mode it takes all eight planes in one handshake and returns the blocks one per handshake. Both sides use valid/ready handshakes, and a transfer happens on a rising clock edge where valid and ready are both high.

Top module: `aes_bitslice_xpose`

## Requirements
- R1: Bytes of an AES block are numbered i = 4·column + row, and byte i occupies block bits [8i+7:8i], where bit 0 is the byte's LSB. Plane k occupies bus bits [128k+127:128k]. Bit k of byte (row r, column c) of block b sits at plane k, bit r·32 + c·8 + b.
- R2: In pack mode the blocks accepted on consecutive beats become blocks 0 to 7 in order. `pln_out_valid` stays low until the eighth beat is accepted, and it is high in the cycle after that beat.
- R3: While `pln_out_valid` is high and `pln_out_ready` is low, `pln_out` and `pln_out_valid` hold their values. After the plane handshake the block returns to idle.
- R4: In unpack mode, `pln_in_ready` is high while idle. In the cycle after the planes are accepted, `blk_out_valid` is high with block 0. Blocks 1 to 7 follow, one per output handshake, each built from the inverse of the R1 mapping. After block 7 is taken, the block is idle.
- R5: While `blk_out_valid` is high and `blk_out_ready` is low, `blk_out` and `blk_out_valid` hold their values.
- R6: Packing eight blocks and then unpacking the resulting planes returns the original blocks bit-exactly.
- R7: A synchronous reset clears the beat counter and both output valid flags. Afterwards the block is idle: `blk_in_ready` equals `!unpack_sel` and `pln_in_ready` equals `unpack_sel`.
- R8: No input is accepted while its ready is low. Block beats offered while planes are being presented, and planes offered during a pack fill, leave the outputs unchanged. At most one of `blk_in_ready`, `pln_in_ready`, `pln_out_valid` and `blk_out_valid` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| unpack_sel | input | 1 | Direction of the next batch: 0 = pack, 1 = unpack; read only when idle |
| blk_in_valid | input | 1 | An AES block is offered on `blk_in` |
| blk_in_ready | output | 1 | The block can take an AES block beat |
| blk_in | input | 128 | AES block in standard byte order |
| pln_in_valid | input | 1 | Eight planes are offered on `pln_in` |
| pln_in_ready | output | 1 | The block can take a set of planes |
| pln_in | input | 1024 | Eight bit planes, plane k at bits [128k+127:128k] |
| pln_out_valid | output | 1 | Packed planes are available |
| pln_out_ready | input | 1 | The consumer takes the planes |
| pln_out | output | 1024 | Eight bit planes, same layout as `pln_in` |
| blk_out_valid | output | 1 | An unpacked AES block is available |
| blk_out_ready | input | 1 | The consumer takes the block |
| blk_out | output | 128 | AES block in standard byte order |

## Verification
In pack mode the planes are due one cycle after the eighth accepted beat. The bench checks that `pln_out_valid` is still low after the seventh beat and high just after the edge that takes the eighth. In unpack mode block 0 is due one cycle after the plane handshake, and each later block is due one cycle after the handshake before it. The bench drives inputs one time unit after the rising edge. A scoreboard monitor samples on the falling edge and compares each transfer against queued expectations from a reference mapping, so every comparison lands on the cycle when the transfer actually takes place, including across deliberate stalls.

// File: rtl/aes_bitslice_xpose.sv
module aes_bitslice_xpose #(
  parameter int NBLK = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 unpack_sel,
  input  logic                 blk_in_valid,
  output logic                 blk_in_ready,
  input  logic [16*NBLK-1:0]   blk_in,
  input  logic                 pln_in_valid,
  output logic                 pln_in_ready,
  input  logic [128*NBLK-1:0]  pln_in,
  output logic                 pln_out_valid,
  input  logic                 pln_out_ready,
  output logic [128*NBLK-1:0]  pln_out,
  output logic                 blk_out_valid,
  input  logic                 blk_out_ready,
  output logic [16*NBLK-1:0]   blk_out
);
  localparam int PW = 16 * NBLK;
  localparam int RW = 4 * NBLK;
  localparam int BW = 16 * NBLK;
  localparam int CW = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBLK - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_PRES, S_DRAIN} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [8*PW-1:0] pl;

  assign blk_in_ready  = (st == S_IDLE && !unpack_sel) || st == S_FILL;
  assign pln_in_ready  = st == S_IDLE && unpack_sel;
  assign pln_out_valid = st == S_PRES;
  assign blk_out_valid = st == S_DRAIN;
  assign pln_out       = pl;

  wire blk_acc = blk_in_valid && blk_in_ready;
  wire pln_acc = pln_in_valid && pln_in_ready;
  wire pln_tx  = pln_out_valid && pln_out_ready;
  wire blk_tx  = blk_out_valid && blk_out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (blk_acc) begin
            if (cnt == LAST) begin st <= S_PRES; cnt <= '0; end
            else begin st <= S_FILL; cnt <= cnt + 1'b1; end
          end else if (pln_acc) begin
            st  <= S_DRAIN;
            cnt <= '0;
          end
        end
        S_FILL: if (blk_acc) begin
          if (cnt == LAST) begin st <= S_PRES; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_PRES: if (pln_tx) st <= S_IDLE;
        S_DRAIN: if (blk_tx) begin
          if (cnt == LAST) begin st <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pln_acc) begin
      pl <= pln_in;
    end else if (blk_acc) begin
      for (int k = 0; k < 8; k++)
        for (int r = 0; r < 4; r++)
          for (int c = 0; c < 4; c++)
            pl[k*PW + r*RW + c*NBLK + int'(cnt)] <= blk_in[(4*c + r)*8 + k];
    end
  end

  always_comb begin
    blk_out = '0;
    for (int k = 0; k < 8; k++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          blk_out[(4*c + r)*8 + k] = pl[k*PW + r*RW + c*NBLK + int'(cnt)];
  end

  assert_early_planes_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pln_out_valid) |-> $past(blk_in_valid && blk_in_ready && cnt == LAST));
  assert_no_output_mid_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (blk_in_valid && blk_in_ready && cnt != LAST) |=> !pln_out_valid);
  assert_plane_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (pln_out_valid && !pln_out_ready) |=> (pln_out_valid && $stable(pln_out)));
  assert_drain_start_R4: assert property (@(posedge clk) disable iff (rst)
    (pln_in_valid && pln_in_ready) |=> (blk_out_valid && cnt == '0));
  assert_block_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (blk_out_valid && !blk_out_ready) |=> (blk_out_valid && $stable(blk_out)));
  assert_one_side_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({blk_in_ready, pln_in_ready, pln_out_valid, blk_out_valid}));
endmodule

// File: tb/aes_bitslice_xpose_bench.sv
module aes_bitslice_xpose_bench;
  typedef logic [127:0] blk8_t [8];

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst = 1, unpack_sel = 0;
  logic blk_in_valid = 0, pln_in_valid = 0, pln_out_ready = 0, blk_out_ready = 0;
  logic [127:0] blk_in = '0;
  logic [1023:0] pln_in = '0;
  logic blk_in_ready, pln_in_ready, pln_out_valid, blk_out_valid;
  logic [1023:0] pln_out;
  logic [127:0] blk_out;

  int checks = 0, bad = 0;
  logic [1023:0] exp_pl[$];
  logic [127:0]  exp_bk[$];
  logic [1023:0] got_pl[$];

  aes_bitslice_xpose u_aes_bitslice_xpose (
    .clk(clk), .rst(rst), .unpack_sel(unpack_sel),
    .blk_in_valid(blk_in_valid), .blk_in_ready(blk_in_ready), .blk_in(blk_in),
    .pln_in_valid(pln_in_valid), .pln_in_ready(pln_in_ready), .pln_in(pln_in),
    .pln_out_valid(pln_out_valid), .pln_out_ready(pln_out_ready), .pln_out(pln_out),
    .blk_out_valid(blk_out_valid), .blk_out_ready(blk_out_ready), .blk_out(blk_out));

  function automatic logic [1023:0] ref_pack(input blk8_t b);
    logic [1023:0] p = '0;
    for (int k = 0; k < 8; k++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          for (int bb = 0; bb < 8; bb++)
            p[k*128 + r*32 + c*8 + bb] = b[bb][(4*c + r)*8 + k];
    return p;
  endfunction

  function automatic logic [127:0] ref_unpack(input logic [1023:0] p, input int bb);
    logic [127:0] o = '0;
    for (int k = 0; k < 8; k++)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          o[(4*c + r)*8 + k] = p[k*128 + r*32 + c*8 + bb];
    return o;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && pln_out_valid && pln_out_ready) begin
      logic [1023:0] e;
      got_pl.push_back(pln_out);
      if (exp_pl.size() == 0) chk(0, "R1 unexpected planes", pln_out[127:0], '0);
      else begin
        e = exp_pl.pop_front();
        for (int k = 0; k < 8; k++)
          chk(pln_out[k*128 +: 128] == e[k*128 +: 128], "R1/R2 plane content",
              pln_out[k*128 +: 128], e[k*128 +: 128]);
      end
    end
    if (!rst && blk_out_valid && blk_out_ready) begin
      logic [127:0] e;
      if (exp_bk.size() == 0) chk(0, "R4 unexpected block", blk_out, '0);
      else begin
        e = exp_bk.pop_front();
        chk(blk_out == e, "R4/R6 block content and order", blk_out, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pack_batch(input blk8_t b, input int stall);
    logic [1023:0] snap;
    exp_pl.push_back(ref_pack(b));
    unpack_sel = 0;
    for (int i = 0; i < 8; i++) begin
      blk_in_valid = 1; blk_in = b[i];
      while (!blk_in_ready) step();
      if (i == 3) pln_in_valid = 1;
      step();
      pln_in_valid = 0;
      if (i == 6) chk(pln_out_valid == 0, "R2 no planes after seventh beat", 128'(pln_out_valid), 0);
    end
    blk_in_valid = 0;
    chk(pln_out_valid == 1, "R2 planes valid after eighth beat", 128'(pln_out_valid), 1);
    snap = pln_out;
    blk_in_valid = 1; blk_in = rnd128();
    for (int s = 0; s < stall; s++) begin
      chk(blk_in_ready == 0, "R8 no block ready while presenting", 128'(blk_in_ready), 0);
      step();
    end
    blk_in_valid = 0;
    chk(pln_out_valid == 1 && pln_out == snap, "R3 planes held under stall",
        pln_out[127:0], snap[127:0]);
    pln_out_ready = 1;
    step();
    pln_out_ready = 0;
    chk(pln_out_valid == 0, "R3 idle after plane handshake", 128'(pln_out_valid), 0);
  endtask

  task automatic unpack_batch(input logic [1023:0] p, input blk8_t e, input bit stall);
    logic [127:0] snap;
    for (int i = 0; i < 8; i++) exp_bk.push_back(e[i]);
    unpack_sel = 1;
    #1;
    chk(pln_in_ready == 1 && blk_in_ready == 0, "R4 plane ready when idle", 128'({pln_in_ready, blk_in_ready}), 2);
    pln_in_valid = 1; pln_in = p;
    while (!pln_in_ready) step();
    step();
    pln_in_valid = 0; unpack_sel = 0;
    chk(blk_out_valid == 1, "R4 block 0 valid one cycle after planes", 128'(blk_out_valid), 1);
    for (int i = 0; i < 8; i++) begin
      if (stall && (i % 3 == 1)) begin
        snap = blk_out;
        blk_out_ready = 0;
        step(); step();
        chk(blk_out_valid == 1 && blk_out == snap, "R5 block held under stall", blk_out, snap);
      end
      blk_out_ready = 1;
      step();
      blk_out_ready = 0;
    end
    chk(blk_out_valid == 0, "R4 idle after block 7", 128'(blk_out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    blk8_t b, z, w;
    logic [1023:0] p;
    step(); step();
    rst = 0;
    #1;
    chk(!pln_out_valid && !blk_out_valid && blk_in_ready && !pln_in_ready, "R7 reset state",
        128'({pln_out_valid, blk_out_valid, blk_in_ready, pln_in_ready}), 128'b0010);

    for (int i = 0; i < 8; i++) b[i] = rnd128();
    pack_batch(b, 3);
    for (int i = 0; i < 8; i++) z[i] = '0;
    pack_batch(z, 0);
    for (int i = 0; i < 8; i++) w[i] = 128'(1) << (i * 17);
    pack_batch(w, 1);

    p = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
         $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
         $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
         $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < 8; i++) w[i] = ref_unpack(p, i);
    unpack_batch(p, w, 1);
    p = '0; p[5*128 + 2*32 + 3*8 + 6] = 1;
    for (int i = 0; i < 8; i++) w[i] = ref_unpack(p, i);
    unpack_batch(p, w, 0);

    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 8; i++) b[i] = rnd128();
      pack_batch(b, t);
      p = got_pl[got_pl.size() - 1];
      unpack_batch(p, b, t[0]);
    end

    unpack_sel = 0;
    for (int i = 0; i < 3; i++) begin
      blk_in_valid = 1; blk_in = rnd128(); step();
    end
    blk_in_valid = 0;
    rst = 1; step(); rst = 0; #1;
    chk(!pln_out_valid && !blk_out_valid && blk_in_ready, "R7 mid-fill reset clears state",
        128'({pln_out_valid, blk_out_valid, blk_in_ready}), 128'b001);
    for (int i = 0; i < 8; i++) b[i] = rnd128();
    pack_batch(b, 0);

    repeat (3) step();
    chk(exp_pl.size() == 0 && exp_bk.size() == 0, "R2/R4 all expected results seen",
        128'(exp_pl.size() + exp_bk.size()), 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule